// File: doc/BRIEF.md
# Debug Entry Context Capture Unit

This block keeps the processor context that a debugger needs once the core has stopped in its background debug state. The core raises one of three entry events: a hardware breakpoint, a background instruction or a double bus fault. On that event the unit stores four values. The first is a cause code in a temporary register. The second is the return address where fetching will resume. The third is the start address of the last completed instruction. The fourth is the address of the most recent bus cycle. The debug command logic reads and changes these registers through a small select/strobe register port.

The temporary register also serves as scratch storage for later debug commands, so the cause code survives only until a command writes that register. A debugger must read it first. When the core leaves the debug state, the unit checks the return address. If that address is odd, it raises an address-error pulse at the moment prefetching restarts. The register port is plain control: it has no back-pressure. A read is returned on the cycle after the strobe, and a write takes effect at the next clock edge.

Top module: `dbg_ctx_capture`

## Requirements
- R1: On debug entry the temporary register is loaded with a cause code. A double bus fault loads the status word in bits 31:16 and 0xFFFF in bits 15:0. A background instruction loads 0x00000001. A hardware breakpoint loads 0x00000000. When events coincide, the double bus fault wins over the background instruction, which wins over the breakpoint.
- R2: A port write to the temporary register while in debug replaces the cause code, and the written value is read back.
- R3: On entry, the current-instruction register takes the current instruction pointer with bit 0 cleared. The one exception is a double bus fault with `init_fetch` high, which loads 0xFFFFFFFF. A port write to this register stores the data with bit 0 cleared.
- R4: Outside debug, the fault address register loads `bus_addr` on every cycle with `bus_done` or `bus_fault` high. After a double bus fault it therefore holds the last bus cycle's address.
- R5: On entry, the return program counter loads `next_pc`. A port write to it while in debug takes effect at the next clock edge.
- R6: While in debug, the fault address register does not change on bus strobes. Port writes to it are ignored.
- R7: With `reg_rd` high, `reg_rdata` shows the selected register after the next edge. The select codes are 0 for temporary, 1 for fault address, 2 for return counter and 3 for current instruction. Otherwise `reg_rdata` holds its value.
- R8: `resume` while in debug clears `in_debug` at the next edge. If the return counter is odd at that point, `addr_err` is high for exactly that one following cycle. Otherwise it stays low.
- R9: Entry events are ignored while already in debug, and port writes are ignored outside debug.
- R10: Reset clears all four registers and `reg_rdata`, and leaves `in_debug` and `addr_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_bkpt | input | 1 | Hardware breakpoint entry event |
| ev_bgnd | input | 1 | Background instruction entry event |
| ev_dbf | input | 1 | Double bus fault entry event |
| init_fetch | input | 1 | Fault happened during the initial stack/program pointer fetch |
| ssw | input | 16 | Special status word |
| bus_done | input | 1 | A bus cycle completed this clock |
| bus_fault | input | 1 | A bus cycle ended in a bus or address error |
| bus_addr | input | 32 | Address of the current bus cycle |
| cur_pc | input | 32 | Start of the last completed instruction |
| next_pc | input | 32 | Next fetch address |
| resume | input | 1 | Leave the debug state |
| reg_sel | input | 2 | Register select |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| in_debug | output | 1 | Core is in the debug state |
| addr_err | output | 1 | Odd resume address error pulse |

## Verification
The entry path is exercised separately with each of the three causes, then with all three at once, so that both the codes and their priority can be told apart. A double bus fault is applied once with the initial-fetch flag high and once with it low, which separates the all-ones marker from the normal even capture. Bus strobes and port writes are applied both inside and outside debug, which shows the freeze and the write gating. Resume is tried with an odd and with an even return address, which distinguishes the error pulse from a plain exit.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  typedef enum logic [1:0] {
    SEL_TEMP = 2'd0,
    SEL_FAR  = 2'd1,
    SEL_RPC  = 2'd2,
    SEL_PCC  = 2'd3
  } dcc_sel_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_BKPT = 2'd1,
    CAUSE_BGND = 2'd2,
    CAUSE_DBF  = 2'd3
  } dcc_cause_e;
endpackage

// File: rtl/dcc_entry_code.sv
module dcc_entry_code
  import dcc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic            in_debug,
  input  logic            ev_bkpt,
  input  logic            ev_bgnd,
  input  logic            ev_dbf,
  input  logic            init_fetch,
  input  logic [AW/2-1:0] ssw,
  input  logic [AW-1:0]   cur_pc,
  output logic            entry,
  output logic [AW-1:0]   code,
  output logic [AW-1:0]   pcc_val
);
  localparam int HW = AW / 2;

  dcc_cause_e cause;

  always_comb begin
    if (ev_dbf)       cause = CAUSE_DBF;
    else if (ev_bgnd) cause = CAUSE_BGND;
    else if (ev_bkpt) cause = CAUSE_BKPT;
    else              cause = CAUSE_NONE;
  end

  assign entry = !in_debug && (cause != CAUSE_NONE);

  always_comb begin
    case (cause)
      CAUSE_DBF:  code = {ssw, {HW{1'b1}}};
      CAUSE_BGND: code = {{(AW-1){1'b0}}, 1'b1};
      default:    code = '0;
    endcase
  end

  always_comb begin
    if (cause == CAUSE_DBF && init_fetch) pcc_val = '1;
    else                                  pcc_val = {cur_pc[AW-1:1], 1'b0};
  end
endmodule

// File: rtl/dcc_ctx_regs.sv
module dcc_ctx_regs
  import dcc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_debug,
  input  logic          entry,
  input  logic [AW-1:0] code,
  input  logic [AW-1:0] pcc_val,
  input  logic [AW-1:0] next_pc,
  input  logic          far_upd,
  input  logic [AW-1:0] bus_addr,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] temp_q,
  output logic [AW-1:0] far_q,
  output logic [AW-1:0] rpc_q,
  output logic [AW-1:0] pcc_q
);
  logic wr_ok;
  assign wr_ok = wr_en && in_debug;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) far_q <= '0;
    else if (far_upd && !in_debug) far_q <= bus_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temp_q <= '0;
      rpc_q  <= '0;
      pcc_q  <= '0;
    end else if (entry) begin
      temp_q <= code;
      rpc_q  <= next_pc;
      pcc_q  <= pcc_val;
    end else if (wr_ok) begin
      case (dcc_sel_e'(wr_sel))
        SEL_TEMP: temp_q <= wdata;
        SEL_RPC:  rpc_q  <= wdata;
        SEL_PCC:  pcc_q  <= {wdata[AW-1:1], 1'b0};
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/dcc_mode_ctl.sv
module dcc_mode_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic entry,
  input  logic resume,
  input  logic rpc_odd,
  output logic in_debug,
  output logic addr_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_debug <= 1'b0;
      addr_err <= 1'b0;
    end else begin
      addr_err <= in_debug && resume && rpc_odd;
      if (entry)                   in_debug <= 1'b1;
      else if (in_debug && resume) in_debug <= 1'b0;
    end
  end
endmodule

// File: rtl/dbg_ctx_capture.sv
module dbg_ctx_capture
  import dcc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_bkpt,
  input  logic            ev_bgnd,
  input  logic            ev_dbf,
  input  logic            init_fetch,
  input  logic [AW/2-1:0] ssw,
  input  logic            bus_done,
  input  logic            bus_fault,
  input  logic [AW-1:0]   bus_addr,
  input  logic [AW-1:0]   cur_pc,
  input  logic [AW-1:0]   next_pc,
  input  logic            resume,
  input  logic [1:0]      reg_sel,
  input  logic            reg_rd,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_wdata,
  output logic [AW-1:0]   reg_rdata,
  output logic            in_debug,
  output logic            addr_err
);
  logic          entry;
  logic [AW-1:0] code, pcc_val;
  logic [AW-1:0] temp_q, far_q, rpc_q, pcc_q;

  dcc_entry_code #(.AW(AW)) u_code (
    .in_debug(in_debug), .ev_bkpt(ev_bkpt), .ev_bgnd(ev_bgnd), .ev_dbf(ev_dbf),
    .init_fetch(init_fetch), .ssw(ssw), .cur_pc(cur_pc),
    .entry(entry), .code(code), .pcc_val(pcc_val)
  );

  dcc_ctx_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .in_debug(in_debug), .entry(entry), .code(code),
    .pcc_val(pcc_val), .next_pc(next_pc), .far_upd(bus_done || bus_fault),
    .bus_addr(bus_addr), .wr_en(reg_wr), .wr_sel(reg_sel), .wdata(reg_wdata),
    .temp_q(temp_q), .far_q(far_q), .rpc_q(rpc_q), .pcc_q(pcc_q)
  );

  dcc_mode_ctl u_mode (
    .clk(clk), .rst_n(rst_n), .entry(entry), .resume(resume),
    .rpc_odd(rpc_q[0]), .in_debug(in_debug), .addr_err(addr_err)
  );

  logic [AW-1:0] rd_mux;
  always_comb begin
    case (dcc_sel_e'(reg_sel))
      SEL_TEMP: rd_mux = temp_q;
      SEL_FAR:  rd_mux = far_q;
      SEL_RPC:  rd_mux = rpc_q;
      default:  rd_mux = pcc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/dcc_checker.sv
module dcc_checker #(
  parameter int AW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ev_dbf,
  input logic [AW/2-1:0] ssw,
  input logic            resume,
  input logic            in_debug,
  input logic            addr_err,
  input logic [AW-1:0]   far_q,
  input logic [AW-1:0]   rpc_q,
  input logic [AW-1:0]   pcc_q,
  input logic [AW-1:0]   temp_q
);
  localparam int HW = AW / 2;

  // R1: double bus fault entry code
  a_r1_dbf_code: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ev_dbf && !in_debug) |-> (temp_q[HW-1:0] == {HW{1'b1}} && temp_q[AW-1:HW] == $past(ssw)));

  // R3: only the all-ones marker may be odd
  a_r3_pcc_even: assert property (@(posedge clk) disable iff (!rst_n)
    pcc_q[0] |-> (pcc_q == {AW{1'b1}}));

  // R6: fault address frozen in debug
  a_r6_far_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_debug) |-> $stable(far_q));

  // R8: error pulse only after an odd resume from debug
  a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> $past(in_debug && resume && rpc_q[0]));

  // R8: the pulse comes with the exit
  a_r8_err_exit: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> !in_debug);
endmodule

bind dbg_ctx_capture dcc_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_dbf(ev_dbf), .ssw(ssw), .resume(resume),
  .in_debug(in_debug), .addr_err(addr_err), .far_q(far_q), .rpc_q(rpc_q),
  .pcc_q(pcc_q), .temp_q(temp_q)
);

// File: tb/dbg_ctx_capture_tb_top.sv
module dbg_ctx_capture_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic ev_bkpt = 0, ev_bgnd = 0, ev_dbf = 0, init_fetch = 0;
  logic [15:0] ssw = 0;
  logic bus_done = 0, bus_fault = 0;
  logic [31:0] bus_addr = 0, cur_pc = 0, next_pc = 0;
  logic resume = 0;
  logic [1:0] reg_sel = 0;
  logic reg_rd = 0, reg_wr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic in_debug, addr_err;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dbg_ctx_capture dut_i (.*);

  // behavioural reference model
  logic        m_dbg = 0, m_aerr = 0;
  logic [31:0] m_reg [4];
  logic [31:0] m_rdata = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dbg = 0; m_aerr = 0; m_rdata = 0;
      foreach (m_reg[i]) m_reg[i] = 0;
    end else begin
      logic [31:0] old [4];
      logic go;
      old = m_reg;
      if (reg_rd) m_rdata = old[reg_sel];
      m_aerr = m_dbg && resume && old[2][0];
      if (!m_dbg && (bus_done || bus_fault)) m_reg[1] = bus_addr;
      go = !m_dbg && (ev_bkpt || ev_bgnd || ev_dbf);
      if (go) begin
        m_reg[0] = ev_dbf ? {ssw, 16'hFFFF} : (ev_bgnd ? 32'd1 : 32'd0);
        m_reg[2] = next_pc;
        m_reg[3] = (ev_dbf && init_fetch) ? 32'hFFFF_FFFF : {cur_pc[31:1], 1'b0};
        m_dbg = 1;
      end else if (m_dbg) begin
        if (reg_wr) begin
          if (reg_sel == 0) m_reg[0] = reg_wdata;
          if (reg_sel == 2) m_reg[2] = reg_wdata;
          if (reg_sel == 3) m_reg[3] = {reg_wdata[31:1], 1'b0};
        end
        if (resume) m_dbg = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (reg_rdata !== m_rdata || in_debug !== m_dbg || addr_err !== m_aerr) begin
        bad++;
        $display("FAIL model R7/R8 rdata=%h/%h dbg=%b/%b aerr=%b/%b",
                 reg_rdata, m_rdata, in_debug, m_dbg, addr_err, m_aerr);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic clear();
    ev_bkpt = 0; ev_bgnd = 0; ev_dbf = 0; init_fetch = 0; bus_done = 0;
    bus_fault = 0; resume = 0; reg_rd = 0; reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    tick(); reg_sel = s; reg_rd = 1;
    @(negedge clk); v = reg_rdata; #1 reg_rd = 0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    tick(); reg_sel = s; reg_wdata = d; reg_wr = 1;
    tick(); reg_wr = 0;
  endtask

  task automatic bus(input logic [31:0] a, input logic f);
    tick(); bus_addr = a; bus_done = !f; bus_fault = f;
    tick(); clear();
  endtask

  task automatic enter(input logic b, input logic g, input logic d, input logic ifch);
    tick(); ev_bkpt = b; ev_bgnd = g; ev_dbf = d; init_fetch = ifch;
    tick(); clear();
  endtask

  task automatic leave(output logic aerr);
    tick(); resume = 1;
    @(negedge clk); aerr = addr_err; #1 clear();
  endtask

  initial begin
    logic [31:0] v;
    logic e;
    repeat (3) tick();
    rst_n = 1;
    // R10 reset state
    chk("R10 dbg", {31'd0, in_debug}, 0);
    chk("R10 aerr", {31'd0, addr_err}, 0);
    for (int i = 0; i < 4; i++) begin rd(i[1:0], v); chk("R10 reg", v, 0); end

    // R4 bus cycles, then breakpoint entry
    bus(32'h0000_1000, 0);
    bus(32'h0000_2004, 1);
    cur_pc = 32'h0000_3003; next_pc = 32'h0000_3010;
    enter(1, 0, 0, 0);
    chk("R9 in_debug set", {31'd0, in_debug}, 1);
    rd(0, v); chk("R1 bkpt code", v, 32'h0);
    rd(1, v); chk("R4 far last fault", v, 32'h0000_2004);
    rd(2, v); chk("R5 rpc", v, 32'h0000_3010);
    rd(3, v); chk("R3 pcc even", v, 32'h0000_3002);

    // R6 freeze, R9 entry ignored in debug
    bus(32'h0000_5555, 0);
    wr(1, 32'hDEAD_BEEF);
    rd(1, v); chk("R6 far frozen", v, 32'h0000_2004);
    ssw = 16'h1234; enter(0, 0, 1, 1);
    rd(0, v); chk("R9 second entry ignored", v, 32'h0);
    // R2 scratch overwrite
    wr(0, 32'hCAFE_0001);
    rd(0, v); chk("R2 temp overwrite", v, 32'hCAFE_0001);
    wr(3, 32'h0000_7777);
    rd(3, v); chk("R3 pcc write even", v, 32'h0000_7776);
    // R5/R8 odd resume
    wr(2, 32'h0000_4001);
    rd(2, v); chk("R5 rpc write", v, 32'h0000_4001);
    leave(e);
    chk("R8 aerr odd", {31'd0, e}, 1);
    chk("R8 exit", {31'd0, in_debug}, 0);
    tick(); chk("R8 one pulse", {31'd0, addr_err}, 0);

    // R9 write outside debug ignored; R1 background code
    wr(0, 32'h1111_1111);
    next_pc = 32'h0000_6000;
    enter(0, 1, 0, 0);
    rd(0, v); chk("R1 bgnd code", v, 32'h1);
    leave(e);
    chk("R8 even no err", {31'd0, e}, 0);

    // R1 double fault at init fetch, R3 marker, R4 last cycle
    bus(32'h0000_8888, 1);
    bus(32'h0000_9990, 1);
    ssw = 16'hA5C3;
    enter(0, 0, 1, 1);
    rd(0, v); chk("R1 dbf code", v, 32'hA5C3_FFFF);
    rd(3, v); chk("R3 dbf marker", v, 32'hFFFF_FFFF);
    rd(1, v); chk("R4 dbf last addr", v, 32'h0000_9990);
    leave(e);

    // R1 priority with all events, dbf without init fetch
    ssw = 16'h0042; cur_pc = 32'h0000_ABCD;
    enter(1, 1, 1, 0);
    rd(0, v); chk("R1 priority", v, 32'h0042_FFFF);
    rd(3, v); chk("R3 dbf normal", v, 32'h0000_ABCC);
    leave(e);
    // R1 bgnd beats bkpt
    enter(1, 1, 0, 0);
    rd(0, v); chk("R1 bgnd over bkpt", v, 32'h1);
    leave(e);
    repeat (3) tick();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule